// File: doc/BRIEF.md
# Eye Feature Detection Sequencer

This block controls one frame of a column-parallel binary image pipeline that finds two features in an infrared eye image. The first is the bright corneal glint. The second is the dark pupil. Each clock cycle the block names one row of the image array. During a load pass it turns that row's pixel intensities into one flag bit per column, and it gives the row-sequential morphology array its opcode: load, shrink or expand. A projection unit outside this block reports after every pass whether any flag is still set, together with the coordinates of the surviving pixels.

The frame runs in a fixed order. The glint mask is loaded and then shrunk until it vanishes. The pupil mask is loaded next; it includes the glint pixels, so the glint does not punch a hole in the pupil. The pupil mask is expanded a configured number of times and then shrunk until it vanishes. Because each shrink erodes a blob from both sides, a feature's position is the set of coordinates reported one pass before its mask became empty. Stray regions such as lashes or skin are eroded away by the same shrink passes before the last pixel of the feature disappears.

A feature that survives half the image height in shrink passes flags a timeout and ends the frame. A one-cycle done strobe then presents both coordinate pairs, each with its own valid bit.

States:
- IDLE
- SPOT_LOAD
- SPOT_EVAL
- SPOT_ERODE
- PUP_LOAD
- PUP_GROW
- PUP_EVAL
- PUP_ERODE
- REPORT

Transitions:
- IDLE goes to SPOT_LOAD on start.
- Each pass state (SPOT_LOAD, SPOT_ERODE, PUP_LOAD, PUP_GROW, PUP_ERODE) stays put until its last row.
- At the last row, SPOT_LOAD and SPOT_ERODE go to SPOT_EVAL.
- At the last row, PUP_LOAD goes to PUP_GROW if the expand count is non-zero, and to PUP_EVAL otherwise.
- At the last row, PUP_GROW repeats until the expand count is used up, then goes to PUP_EVAL.
- At the last row, PUP_ERODE goes to PUP_EVAL.
- SPOT_EVAL goes to PUP_LOAD if the mask is empty, to REPORT on timeout, and to SPOT_ERODE otherwise.
- PUP_EVAL goes to REPORT if the mask is empty or on timeout, and to PUP_ERODE otherwise.
- REPORT returns to IDLE.

Top module: `eye_feature_seq`

## Requirements
- R1: While reset is held, and after it is released, `morph_op` is 0, `done` is 0, and `timeout_err`, both valid bits and all four coordinates read 0.
- R2: Every pass drives one `morph_op` code for exactly ROWS consecutive cycles, and `row_idx` counts 0 to ROWS-1, one row per clock. The codes are 1 = load, 2 = shrink and 3 = expand. Each pass is followed by one evaluation cycle with code 0, except that a load or expand pass is followed directly by the next expand pass.
- R3: During the glint load, `mask_row` bit c is 1 exactly when pixel c is at least `spot_lo` and at most `spot_hi`, bounds included. Pixel c is `pix_row[c*PIX_W +: PIX_W]`. `mask_row` is 0 whenever `morph_op` is not load.
- R4: During the pupil load, `mask_row` bit c is 1 when pixel c is at most `pup_dark` or at least `pup_glint`.
- R5: The pass sequence is: glint load; glint shrinks; pupil load; pupil expands; pupil shrinks.
- R6: If the projection reports an empty mask after a shrink pass, the feature's valid bit is set and its coordinates are the `proj_x`/`proj_y` sampled after the previous pass.
- R7: If the mask is already empty at its first evaluation (after the load, or after the expands for the pupil), the feature's valid bit and coordinates read 0. An empty glint mask still lets the pupil phase run.
- R8: The expand count `cfg_grow_passes` is sampled when the frame starts, and later changes have no effect. A count of 0 skips expansion.
- R9: A mask still non-empty after ROWS/2 shrink passes sets `timeout_err` and ends the frame with that feature invalid. A glint timeout skips the pupil phase entirely. Vanishing exactly at shrink pass ROWS/2 is a success.
- R10: `done` is high for exactly one cycle per frame. The results stay stable afterwards until the next start.
- R11: `start` is ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| cfg_grow_passes | input | GROW_W | Number of pupil expand passes, sampled at start |
| spot_lo | input | PIX_W | Lower glint level (inclusive) |
| spot_hi | input | PIX_W | Upper glint level (inclusive) |
| pup_dark | input | PIX_W | Pupil dark level; at or below counts as pupil |
| pup_glint | input | PIX_W | Bright level; at or above also counts as pupil |
| pix_row | input | COLS*PIX_W | Intensities of the selected row, column c at bits c*PIX_W |
| proj_empty | input | 1 | Projection unit: no flag remains after the pass |
| proj_x | input | clog2(COLS) | Projection unit: surviving column coordinate |
| proj_y | input | clog2(ROWS) | Projection unit: surviving row coordinate |
| morph_op | output | 2 | 0 none, 1 load, 2 shrink, 3 expand |
| row_idx | output | clog2(ROWS) | Row being processed |
| mask_row | output | COLS | Thresholded flags of the selected row during loads |
| done | output | 1 | One-cycle end-of-frame strobe |
| timeout_err | output | 1 | A feature did not vanish within ROWS/2 shrinks |
| spot_ok | output | 1 | Glint coordinates valid |
| spot_x | output | clog2(COLS) | Glint column |
| spot_y | output | clog2(ROWS) | Glint row |
| pup_ok | output | 1 | Pupil coordinates valid |
| pup_x | output | clog2(COLS) | Pupil column |
| pup_y | output | clog2(ROWS) | Pupil row |

## Verification
The hardest conditions to reach from the ports are the shrink-limit boundaries. One is a mask that vanishes exactly at shrink pass ROWS/2. The other is one that survives it, which must abort either the glint phase or the pupil phase. Both depend on how many passes the morphology array takes, which this block never sees.

The bench models the projection unit as a scripted table. It counts the pass ends it observes on `morph_op` and `row_idx`, and it reports coordinates that change with every pass until a chosen pass index. From that point on it reports an empty mask. Choosing that index per feature places each frame on the boundary, past it, or at zero. The same bench also changes the expand count in mid-frame, and it pulses `start` again in mid-frame.

// File: rtl/eye_seq_pkg.sv
package eye_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_SHRINK = 2'd2,
        OP_EXPAND = 2'd3
    } morph_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SPOT_LOAD,
        ST_SPOT_EVAL,
        ST_SPOT_ERODE,
        ST_PUP_LOAD,
        ST_PUP_GROW,
        ST_PUP_EVAL,
        ST_PUP_ERODE,
        ST_REPORT
    } seq_state_e;

endpackage

// File: rtl/eye_row_scan.sv
module eye_row_scan #(
    parameter int ROWS = 16,
    localparam int YW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [YW-1:0] row_idx,
    output logic          last_row
);
    localparam logic [YW-1:0] LAST = YW'(ROWS - 1);

    assign last_row = run && (row_idx == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            row_idx <= '0;
        end else if (row_idx == LAST) begin
            row_idx <= '0;
        end else begin
            row_idx <= row_idx + 1'b1;
        end
    end
endmodule

// File: rtl/eye_level_mask.sv
module eye_level_mask #(
    parameter int COLS  = 8,
    parameter int PIX_W = 8
) (
    input  logic                  enable,
    input  logic                  pupil_sel,
    input  logic [COLS*PIX_W-1:0] pix_row,
    input  logic [PIX_W-1:0]      spot_lo,
    input  logic [PIX_W-1:0]      spot_hi,
    input  logic [PIX_W-1:0]      pup_dark,
    input  logic [PIX_W-1:0]      pup_glint,
    output logic [COLS-1:0]       mask
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [PIX_W-1:0] level;
        logic             in_window;
        logic             in_pupil;

        assign level     = pix_row[c*PIX_W +: PIX_W];
        assign in_window = (level >= spot_lo) && (level <= spot_hi);
        assign in_pupil  = (level <= pup_dark) || (level >= pup_glint);
        assign mask[c]   = enable && (pupil_sel ? in_pupil : in_window);
    end
endmodule

// File: rtl/eye_blob_track.sv
module eye_blob_track #(
    parameter int XW = 3,
    parameter int YW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic          commit,
    input  logic          found,
    input  logic [XW-1:0] px,
    input  logic [YW-1:0] py,
    output logic          ok,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);
    logic [XW-1:0] prev_x;
    logic [YW-1:0] prev_y;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_x <= '0;
            prev_y <= '0;
            ok     <= 1'b0;
            x      <= '0;
            y      <= '0;
        end else if (sample) begin
            prev_x <= px;
            prev_y <= py;
        end else if (commit) begin
            ok <= found;
            x  <= found ? prev_x : '0;
            y  <= found ? prev_y : '0;
        end
    end
endmodule

// File: rtl/eye_feature_seq.sv
module eye_feature_seq
    import eye_seq_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 8,
    parameter int PIX_W  = 8,
    parameter int GROW_W = 4,
    localparam int XW = $clog2(COLS),
    localparam int YW = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [GROW_W-1:0]     cfg_grow_passes,
    input  logic [PIX_W-1:0]      spot_lo,
    input  logic [PIX_W-1:0]      spot_hi,
    input  logic [PIX_W-1:0]      pup_dark,
    input  logic [PIX_W-1:0]      pup_glint,
    input  logic [COLS*PIX_W-1:0] pix_row,
    input  logic                  proj_empty,
    input  logic [XW-1:0]         proj_x,
    input  logic [YW-1:0]         proj_y,
    output logic [1:0]            morph_op,
    output logic [YW-1:0]         row_idx,
    output logic [COLS-1:0]       mask_row,
    output logic                  done,
    output logic                  timeout_err,
    output logic                  spot_ok,
    output logic [XW-1:0]         spot_x,
    output logic [YW-1:0]         spot_y,
    output logic                  pup_ok,
    output logic [XW-1:0]         pup_x,
    output logic [YW-1:0]         pup_y
);
    localparam int MAX_PASS = ROWS / 2;
    localparam int PCW      = $clog2(MAX_PASS + 1);
    localparam logic [PCW-1:0] PASS_LIMIT = PCW'(MAX_PASS);

    seq_state_e        state, state_nx;
    morph_op_e         op;
    logic [PCW-1:0]    pass_cnt;
    logic [GROW_W-1:0] grow_left;
    logic              last_row;
    logic              at_limit;
    logic              frame_go;
    logic              spot_eval, pup_eval;

    assign frame_go  = (state == ST_IDLE) && start;
    assign at_limit  = (pass_cnt == PASS_LIMIT);
    assign spot_eval = (state == ST_SPOT_EVAL);
    assign pup_eval  = (state == ST_PUP_EVAL);

    eye_row_scan #(.ROWS(ROWS)) scan_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (op != OP_NONE),
        .row_idx  (row_idx),
        .last_row (last_row)
    );

    eye_level_mask #(.COLS(COLS), .PIX_W(PIX_W)) mask_i (
        .enable    (op == OP_LOAD),
        .pupil_sel (state == ST_PUP_LOAD),
        .pix_row   (pix_row),
        .spot_lo   (spot_lo),
        .spot_hi   (spot_hi),
        .pup_dark  (pup_dark),
        .pup_glint (pup_glint),
        .mask      (mask_row)
    );

    eye_blob_track #(.XW(XW), .YW(YW)) spot_trk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (frame_go),
        .sample (spot_eval && !proj_empty),
        .commit (spot_eval && proj_empty),
        .found  (pass_cnt != '0),
        .px     (proj_x),
        .py     (proj_y),
        .ok     (spot_ok),
        .x      (spot_x),
        .y      (spot_y)
    );

    eye_blob_track #(.XW(XW), .YW(YW)) pup_trk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (frame_go),
        .sample (pup_eval && !proj_empty),
        .commit (pup_eval && proj_empty),
        .found  (pass_cnt != '0),
        .px     (proj_x),
        .py     (proj_y),
        .ok     (pup_ok),
        .x      (pup_x),
        .y      (pup_y)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start) state_nx = ST_SPOT_LOAD;
            ST_SPOT_LOAD:  if (last_row) state_nx = ST_SPOT_EVAL;
            ST_SPOT_ERODE: if (last_row) state_nx = ST_SPOT_EVAL;
            ST_SPOT_EVAL: begin
                if (proj_empty)    state_nx = ST_PUP_LOAD;
                else if (at_limit) state_nx = ST_REPORT;
                else               state_nx = ST_SPOT_ERODE;
            end
            ST_PUP_LOAD: begin
                if (last_row) state_nx = (grow_left != '0) ? ST_PUP_GROW : ST_PUP_EVAL;
            end
            ST_PUP_GROW: begin
                if (last_row && grow_left == GROW_W'(1)) state_nx = ST_PUP_EVAL;
            end
            ST_PUP_ERODE:  if (last_row) state_nx = ST_PUP_EVAL;
            ST_PUP_EVAL: begin
                if (proj_empty || at_limit) state_nx = ST_REPORT;
                else                        state_nx = ST_PUP_ERODE;
            end
            ST_REPORT:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // pass bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_cnt    <= '0;
            grow_left   <= '0;
            timeout_err <= 1'b0;
        end else if (frame_go) begin
            pass_cnt    <= '0;
            grow_left   <= cfg_grow_passes;
            timeout_err <= 1'b0;
        end else if (spot_eval || pup_eval) begin
            if (proj_empty) begin
                pass_cnt <= '0;
            end else if (at_limit) begin
                timeout_err <= 1'b1;
            end else begin
                pass_cnt <= pass_cnt + 1'b1;
            end
        end else if (state == ST_PUP_GROW && last_row) begin
            grow_left <= grow_left - 1'b1;
        end
    end

    // state-decoded outputs
    always_comb begin
        op   = OP_NONE;
        done = 1'b0;
        unique case (state)
            ST_SPOT_LOAD, ST_PUP_LOAD:   op = OP_LOAD;
            ST_SPOT_ERODE, ST_PUP_ERODE: op = OP_SHRINK;
            ST_PUP_GROW:                 op = OP_EXPAND;
            ST_REPORT:                   done = 1'b1;
            default:                     op = OP_NONE;
        endcase
    end

    assign morph_op = op;
endmodule

// File: rtl/eye_feature_seq_chk.sv
module eye_feature_seq_chk #(
    parameter int ROWS = 16,
    parameter int COLS = 8,
    localparam int YW = $clog2(ROWS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      morph_op,
    input logic [YW-1:0]   row_idx,
    input logic [COLS-1:0] mask_row,
    input logic            done,
    input logic            timeout_err,
    input logic            pup_ok
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (morph_op != 2'd0 && row_idx != YW'(ROWS - 1)) |=>
            (morph_op == $past(morph_op) && row_idx == $past(row_idx) + 1'b1));

    // R2
    row_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (morph_op == 2'd0) |=> (morph_op == 2'd0 || row_idx == '0));

    // R3
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (morph_op != 2'd1) |-> (mask_row == '0));

    // R9
    timeout_pupil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_err) |-> !pup_ok);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (morph_op == 2'd0));
endmodule

bind eye_feature_seq eye_feature_seq_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .morph_op    (morph_op),
    .row_idx     (row_idx),
    .mask_row    (mask_row),
    .done        (done),
    .timeout_err (timeout_err),
    .pup_ok      (pup_ok)
);

// File: tb/eye_feature_seq_tb.sv
`timescale 1ns/1ps
module eye_feature_seq_tb_top;
    localparam int ROWS   = 16;
    localparam int COLS   = 8;
    localparam int PIX_W  = 8;
    localparam int GROW_W = 4;
    localparam int XW     = $clog2(COLS);
    localparam int YW     = $clog2(ROWS);
    localparam int MAXP   = ROWS / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [GROW_W-1:0] cfg_grow_passes = '0;
    logic [PIX_W-1:0] spot_lo = 8'd200, spot_hi = 8'd240, pup_dark = 8'd40, pup_glint = 8'd230;
    logic [COLS*PIX_W-1:0] pix_row = '0;
    logic proj_empty = 1'b0;
    logic [XW-1:0] proj_x = '0;
    logic [YW-1:0] proj_y = '0;
    logic [1:0] morph_op;
    logic [YW-1:0] row_idx;
    logic [COLS-1:0] mask_row;
    logic done, timeout_err, spot_ok, pup_ok;
    logic [XW-1:0] spot_x, pup_x;
    logic [YW-1:0] spot_y, pup_y;

    always #4 clk = ~clk;

    eye_feature_seq #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .GROW_W(GROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_grow_passes(cfg_grow_passes),
        .spot_lo(spot_lo), .spot_hi(spot_hi), .pup_dark(pup_dark), .pup_glint(pup_glint),
        .pix_row(pix_row), .proj_empty(proj_empty), .proj_x(proj_x), .proj_y(proj_y),
        .morph_op(morph_op), .row_idx(row_idx), .mask_row(mask_row), .done(done),
        .timeout_err(timeout_err), .spot_ok(spot_ok), .spot_x(spot_x), .spot_y(spot_y),
        .pup_ok(pup_ok), .pup_x(pup_x), .pup_y(pup_y)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // scripted projection unit and monitor state
    int spot_v = 1, pup_v = 1;
    int loads_seen = 0, phase_p = 0;
    int seq_log[64];
    int seq_len = 0;
    int op_cycles[4];
    int done_seen = 0;
    logic cap_err, cap_sok, cap_pok;
    logic [XW-1:0] cap_sx, cap_px;
    logic [YW-1:0] cap_sy, cap_py;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cx(input int f, input int p);
        return (f * 3 + p + 1) % COLS;
    endfunction
    function automatic int cy(input int f, input int p);
        return (f * 5 + 2 * p + 1) % ROWS;
    endfunction

    function automatic logic [PIX_W-1:0] pix_val(input int r, input int c, input int which);
        if (r == 0 && which == 0 && c < 4) begin
            case (c)
                0: return spot_lo;
                1: return spot_hi;
                2: return spot_lo - 1'b1;
                default: return spot_hi + 1'b1;
            endcase
        end
        if (r == 0 && which == 1 && c < 4) begin
            case (c)
                0: return pup_dark;
                1: return pup_dark + 1'b1;
                2: return pup_glint;
                default: return pup_glint - 1'b1;
            endcase
        end
        return PIX_W'((r * 37 + c * 53 + which * 11) % 256);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int c = 0; c < COLS; c++)
            pix_row[c*PIX_W +: PIX_W] = pix_val(int'(row_idx), c, loads_seen);
        #1;
        if (rst_n && morph_op == 2'd1) begin
            for (int c = 0; c < COLS; c++) begin
                logic [PIX_W-1:0] v;
                logic e;
                v = pix_val(int'(row_idx), c, loads_seen);
                if (loads_seen == 0) e = (v >= spot_lo) && (v <= spot_hi);
                else                 e = (v <= pup_dark) || (v >= pup_glint);
                chk(mask_row[c] == e, loads_seen == 0 ? "R3" : "R4", "mask bit",
                    mask_row[c], e);
            end
        end
        if (rst_n && morph_op != 2'd0) begin
            op_cycles[morph_op]++;
            if (row_idx == YW'(ROWS - 1)) begin
                int vanish;
                if (seq_len < 64) seq_log[seq_len] = int'(morph_op);
                seq_len++;
                if (morph_op == 2'd1) begin
                    loads_seen++;
                    phase_p = 0;
                end else if (morph_op == 2'd2) begin
                    phase_p++;
                end
                vanish = (loads_seen <= 1) ? spot_v : pup_v;
                proj_empty = (phase_p >= vanish);
                proj_x = XW'(cx(loads_seen - 1, phase_p));
                proj_y = YW'(cy(loads_seen - 1, phase_p));
            end
        end
        if (done) begin
            done_seen++;
            cap_err = timeout_err; cap_sok = spot_ok; cap_pok = pup_ok;
            cap_sx = spot_x; cap_sy = spot_y; cap_px = pup_x; cap_py = pup_y;
        end
    end

    task automatic check_reset();
        @(negedge clk); #2;
        chk(morph_op == 2'd0 && done == 1'b0, "R1", "op/done in reset", {morph_op, done}, 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(morph_op == 2'd0, "R1", "op after reset", morph_op, 0);
        chk(!done && !timeout_err && !spot_ok && !pup_ok, "R1", "flags after reset",
            {done, timeout_err, spot_ok, pup_ok}, 0);
        chk(spot_x == 0 && spot_y == 0 && pup_x == 0 && pup_y == 0, "R1", "coords after reset",
            {spot_x, spot_y, pup_x, pup_y}, 0);
    endtask

    task automatic run_frame(input int sv, input int ge, input int pv, input bit mid_start,
                             input string name);
        bit spot_to, pup_run, pup_to, e_sok, e_pok, e_err;
        int e_sx, e_sy, e_px, e_py, e_len, n_spot_sh, n_pup_sh, waited;
        int e_seq[64];
        spot_v = sv; pup_v = pv;
        loads_seen = 0; phase_p = 0; seq_len = 0; done_seen = 0;
        for (int i = 0; i < 4; i++) op_cycles[i] = 0;
        spot_to = (sv > MAXP);
        pup_run = !spot_to;
        pup_to  = pup_run && (pv > MAXP);
        e_sok = (sv >= 1) && !spot_to;
        e_pok = pup_run && (pv >= 1) && !pup_to;
        e_err = spot_to || pup_to;
        e_sx = e_sok ? cx(0, sv - 1) : 0;  e_sy = e_sok ? cy(0, sv - 1) : 0;
        e_px = e_pok ? cx(1, pv - 1) : 0;  e_py = e_pok ? cy(1, pv - 1) : 0;
        n_spot_sh = spot_to ? MAXP : sv;
        n_pup_sh  = pup_to ? MAXP : pv;
        e_len = 0;
        e_seq[e_len++] = 1;
        for (int i = 0; i < n_spot_sh; i++) e_seq[e_len++] = 2;
        if (pup_run) begin
            e_seq[e_len++] = 1;
            for (int i = 0; i < ge; i++) e_seq[e_len++] = 3;
            for (int i = 0; i < n_pup_sh; i++) e_seq[e_len++] = 2;
        end

        cfg_grow_passes = GROW_W'(ge);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cfg_grow_passes = GROW_W'(7);   // R8: changes after start have no effect
        if (mid_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;              // R11: ignored mid-frame
            @(negedge clk); start = 1'b0;
        end
        waited = 0;
        while (done_seen == 0 && waited < 4000) begin
            @(negedge clk); waited++;
        end
        chk(done_seen != 0, "R10", {name, " done seen"}, done_seen, 1);
        repeat (4) @(negedge clk);
        #2;
        chk(done_seen == 1, "R11", {name, " done count"}, done_seen, 1);
        chk(cap_err == e_err, "R9", {name, " timeout_err"}, cap_err, e_err);
        chk(cap_sok == e_sok, "R6", {name, " spot_ok"}, cap_sok, e_sok);
        chk(int'(cap_sx) == e_sx && int'(cap_sy) == e_sy, "R6", {name, " spot coords"},
            {cap_sx, cap_sy}, (e_sx << YW) | e_sy);
        chk(cap_pok == e_pok, "R7", {name, " pup_ok"}, cap_pok, e_pok);
        chk(int'(cap_px) == e_px && int'(cap_py) == e_py, "R6", {name, " pupil coords"},
            {cap_px, cap_py}, (e_px << YW) | e_py);
        chk(seq_len == e_len, "R5", {name, " pass count"}, seq_len, e_len);
        for (int i = 0; i < e_len && i < seq_len && i < 64; i++)
            chk(seq_log[i] == e_seq[i], "R5", {name, " pass order"}, seq_log[i], e_seq[i]);
        chk(op_cycles[1] == (pup_run ? 2 : 1) * ROWS, "R2", {name, " load cycles"},
            op_cycles[1], (pup_run ? 2 : 1) * ROWS);
        chk(op_cycles[3] == (pup_run ? ge : 0) * ROWS, "R8", {name, " expand cycles"},
            op_cycles[3], (pup_run ? ge : 0) * ROWS);
        chk(op_cycles[2] == (n_spot_sh + (pup_run ? n_pup_sh : 0)) * ROWS, "R2",
            {name, " shrink cycles"}, op_cycles[2], (n_spot_sh + (pup_run ? n_pup_sh : 0)) * ROWS);
        chk(morph_op == 2'd0 && !done, "R10", {name, " idle after done"}, {morph_op, done}, 0);
        chk(spot_ok == cap_sok && pup_ok == cap_pok && spot_x == cap_sx && spot_y == cap_sy &&
            pup_x == cap_px && pup_y == cap_py && timeout_err == cap_err, "R10",
            {name, " results hold"}, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        run_frame(3, 1, 4, 1'b1, "basic");              // R5 R6 R11
        run_frame(0, 0, MAXP, 1'b0, "empty_spot");      // R7 R8 R9 boundary
        run_frame(MAXP + 1, 2, 2, 1'b0, "spot_timeout"); // R9
        run_frame(1, 2, MAXP + 1, 1'b0, "pupil_timeout"); // R9
        run_frame(2, 3, 0, 1'b0, "empty_pupil");        // R7
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule